// File: doc/BRIEF.md
# Multi-Channel Pulse Interval Logger

This block times the gap between rising edges on ten digital inputs and writes one word per input into an external SRAM on request. A timer clock runs one saturating interval counter per channel. Each input is passed through a three-stage shift register on that clock, and the resulting one-cycle rise pulse has two effects. It stores the running count in the channel's capture register, and it restarts the count and drops any overflow mark. If a channel stays quiet long enough for its counter to reach the top, the next capture stores all ones instead of a count.

Captured values reach the main clock domain through a toggle request/acknowledge handshake with two-flop synchronisers. The main-domain copy therefore changes only when the value sent across is stable. A pulse on the record trigger starts a scan of all channels. The scan visits each channel in turn, and after each channel it spends one cycle presenting that channel's word and address with the write strobe high. At the end of the scan the sequencer returns to rest. Software or a host converts the stored intervals to rate values. That conversion is not part of this block.

Top module: `pulse_interval_logger`

## Requirements
- R1: Bit 15 of every written word is the synchronised level of that channel's input (1 = high) at the time of the scan.
- R2: Bits 14:0 hold P-1, where P is the number of timer-clock rising edges between two consecutive rising edges of the channel input, for P-1 below 0x7FFF.
- R3: When P-1 is 0x7FFF or more, the stored interval is 0x7FFF. This holds both when the terminal count and the restart fall on the same timer edge and when the overflow mark was set earlier.
- R4: A restart clears the overflow mark, so the interval that follows an overflowed one is measured normally.
- R5: An input held high produces exactly one capture. The stored value and the restart do not repeat while the level stays high.
- R6: A scan writes addresses 0 to 9 in ascending order, one write every second main-clock cycle, for exactly ten writes.
- R7: The write strobe is never high for two consecutive cycles and stays low while the sequencer rests.
- R8: A trigger raised while a scan is in progress has no effect. The scan still makes exactly ten writes and no further scan follows.
- R9: After reset the write strobe, address and data outputs are zero. A scan made before any input edge writes zero for every channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main clock for the sequencer and write outputs |
| clk_tick | input | 1 | Timer clock that advances the interval counters |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| chan_in | input | 10 | Raw digital inputs, one bit per channel |
| rec_trig | input | 1 | Record trigger, synchronous to clk_main, starts a scan |
| wr_data | output | 16 | Word being written: level in bit 15, interval in bits 14:0 |
| wr_addr | output | 4 | SRAM address of the word, equal to the channel number |
| wr_en | output | 1 | One-cycle SRAM write strobe |

## Verification
Two timer-domain events can land on the same clock edge: the counter reaching its terminal value, and the restart caused by a new input edge. The bench provokes this by spacing two rising edges exactly 32768 timer edges apart, so the restart meets a counter that is at its maximum while the overflow mark is not yet set. The bench requires 0x7FFF to be stored and the following short interval to be measured exactly. It then repeats the test with a spacing one edge longer, where the mark is already set when the restart arrives. Both cases must produce the same stored value and the same clean recovery.

// File: rtl/pil_pkg.sv
package pil_pkg;
  localparam int CNT_W  = 15;
  localparam int WORD_W = CNT_W + 1;

  typedef logic [CNT_W-1:0] cnt_t;

  localparam cnt_t CNT_MAX = '1;

  // one timer step of the interval counter, sticking at the top value
  function automatic cnt_t cnt_advance(cnt_t c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  // value stored on a capture: the count, or all ones once overflowed
  function automatic cnt_t capture_value(cnt_t c, logic ovf);
    return ovf ? CNT_MAX : c;
  endfunction

  // rising edge between two delayed copies of a level
  function automatic logic rise_seen(logic cur, logic prev);
    return cur & ~prev;
  endfunction
endpackage

// File: rtl/pil_chan_timer.sv
module pil_chan_timer
  import pil_pkg::*;
(
  input  logic clk_tick,
  input  logic rst_n,
  input  logic sig_in,
  output logic level_o,
  output logic clr_o,
  output logic ovf_o,
  output cnt_t cap_o
);
  logic [2:0] stg;
  logic       clr;
  cnt_t       count;
  logic       ovf;
  cnt_t       cap;

  always_ff @(posedge clk_tick or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[1:0], sig_in};
  end

  assign clr = rise_seen(stg[1], stg[2]);

  always_ff @(posedge clk_tick or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
      cap   <= '0;
    end else if (clr) begin
      cap   <= capture_value(count, ovf);
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      count <= cnt_advance(count);
      if (count == CNT_MAX) ovf <= 1'b1;
    end
  end

  assign level_o = stg[1];
  assign clr_o   = clr;
  assign ovf_o   = ovf;
  assign cap_o   = cap;
endmodule

// File: rtl/pil_cdc_word.sv
module pil_cdc_word #(
  parameter int W = 15
) (
  input  logic         clk_src,
  input  logic         clk_dst,
  input  logic         rst_n,
  input  logic         src_evt,
  input  logic [W-1:0] src_word,
  output logic [W-1:0] dst_word
);
  logic         pend;
  logic         req;
  logic [1:0]   ack_sync;
  logic [W-1:0] xfer;
  logic         launch;
  logic [1:0]   req_sync;
  logic         ack;
  logic [W-1:0] shadow;

  assign launch = pend && (req == ack_sync[1]);

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      req      <= 1'b0;
      ack_sync <= '0;
      xfer     <= '0;
    end else begin
      ack_sync <= {ack_sync[0], ack};
      pend     <= src_evt | (pend & ~launch);
      if (launch) begin
        xfer <= src_word;
        req  <= ~req;
      end
    end
  end

  always_ff @(posedge clk_dst or negedge rst_n) begin
    if (!rst_n) begin
      req_sync <= '0;
      ack      <= 1'b0;
      shadow   <= '0;
    end else begin
      req_sync <= {req_sync[0], req};
      if (req_sync[1] != ack) begin
        shadow <= xfer;
        ack    <= req_sync[1];
      end
    end
  end

  assign dst_word = shadow;
endmodule

// File: rtl/pil_scan_fsm.sv
module pil_scan_fsm #(
  parameter int NCH    = 10,
  parameter int ADDR_W = 4,
  parameter int WORD_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         trig,
  input  logic [NCH-1:0][WORD_W-1:0]   words,
  output logic [WORD_W-1:0]            wr_data,
  output logic [ADDR_W-1:0]            wr_addr,
  output logic                         wr_en,
  output logic [ADDR_W-1:0]            state_o
);
  localparam logic [ADDR_W-1:0] ST_SEND  = ADDR_W'(NCH);
  localparam logic [ADDR_W-1:0] ST_IDLE  = ADDR_W'(NCH + 1);
  localparam logic [ADDR_W-1:0] LAST_CH  = ADDR_W'(NCH - 1);

  logic [ADDR_W-1:0] state;
  logic [ADDR_W-1:0] chan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      chan    <= '0;
      wr_data <= '0;
      wr_addr <= '0;
      wr_en   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          wr_en <= 1'b0;
          if (trig) begin
            state <= '0;
            chan  <= '0;
          end
        end
        ST_SEND: begin
          wr_en <= 1'b0;
          if (chan == LAST_CH) begin
            state <= ST_IDLE;
          end else begin
            chan  <= chan + 1'b1;
            state <= chan + 1'b1;
          end
        end
        default: begin
          wr_data <= words[chan];
          wr_addr <= chan;
          wr_en   <= 1'b1;
          state   <= ST_SEND;
        end
      endcase
    end
  end

  assign state_o = state;
endmodule

// File: rtl/pulse_interval_logger.sv
module pulse_interval_logger
  import pil_pkg::*;
#(
  parameter int NCH    = 10,
  parameter int ADDR_W = 4
) (
  input  logic              clk_main,
  input  logic              clk_tick,
  input  logic              rst_n,
  input  logic [NCH-1:0]    chan_in,
  input  logic              rec_trig,
  output logic [WORD_W-1:0] wr_data,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_en
);
  logic [NCH-1:0]             clr_vec;
  logic [NCH-1:0]             ovf_vec;
  logic [NCH-1:0]             lvl_tick;
  logic [NCH-1:0][WORD_W-1:0] word_bus;
  logic [ADDR_W-1:0]          scan_state;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cnt_t       cap;
    cnt_t       cap_main;
    logic [1:0] lvl_sync;

    pil_chan_timer u_tmr (
      .clk_tick (clk_tick),
      .rst_n    (rst_n),
      .sig_in   (chan_in[i]),
      .level_o  (lvl_tick[i]),
      .clr_o    (clr_vec[i]),
      .ovf_o    (ovf_vec[i]),
      .cap_o    (cap)
    );

    pil_cdc_word #(.W(CNT_W)) u_cdc (
      .clk_src  (clk_tick),
      .clk_dst  (clk_main),
      .rst_n    (rst_n),
      .src_evt  (clr_vec[i]),
      .src_word (cap),
      .dst_word (cap_main)
    );

    always_ff @(posedge clk_main or negedge rst_n) begin
      if (!rst_n) lvl_sync <= '0;
      else        lvl_sync <= {lvl_sync[0], lvl_tick[i]};
    end

    assign word_bus[i] = {lvl_sync[1], cap_main};
  end

  pil_scan_fsm #(.NCH(NCH), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fsm (
    .clk     (clk_main),
    .rst_n   (rst_n),
    .trig    (rec_trig),
    .words   (word_bus),
    .wr_data (wr_data),
    .wr_addr (wr_addr),
    .wr_en   (wr_en),
    .state_o (scan_state)
  );
endmodule

// File: rtl/pil_checker.sv
module pil_checker #(
  parameter int NCH    = 10,
  parameter int ADDR_W = 4
) (
  input logic              clk_main,
  input logic              clk_tick,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] scan_state,
  input logic [NCH-1:0]    clr_vec,
  input logic [NCH-1:0]    ovf_vec
);
  localparam logic [ADDR_W-1:0] ST_IDLE = ADDR_W'(NCH + 1);
  localparam logic [ADDR_W-1:0] N_ADDR  = ADDR_W'(NCH);

  assert_wr_single_R7: assert property (@(posedge clk_main) disable iff (!rst_n)
    wr_en |=> !wr_en);

  assert_idle_quiet_R7: assert property (@(posedge clk_main) disable iff (!rst_n)
    (scan_state == ST_IDLE) |-> !wr_en);

  assert_addr_range_R6: assert property (@(posedge clk_main) disable iff (!rst_n)
    wr_en |-> (wr_addr < N_ADDR));

  assert_addr_step_R6: assert property (@(posedge clk_main) disable iff (!rst_n)
    (wr_en && wr_addr != '0) |->
      ($past(wr_en, 2) && ($past(wr_addr, 2) == ADDR_W'(wr_addr - 1'b1))));

  assert_scan_entry_R8: assert property (@(posedge clk_main) disable iff (!rst_n)
    (scan_state == '0) |-> ($past(scan_state) == ST_IDLE));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_clear_drops_ovf_R4: assert property (@(posedge clk_tick) disable iff (!rst_n)
      clr_vec[i] |=> !ovf_vec[i]);

    assert_clear_single_R5: assert property (@(posedge clk_tick) disable iff (!rst_n)
      clr_vec[i] |=> !clr_vec[i]);
  end
endmodule

bind pulse_interval_logger pil_checker #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk_main   (clk_main),
  .clk_tick   (clk_tick),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .scan_state (scan_state),
  .clr_vec    (clr_vec),
  .ovf_vec    (ovf_vec)
);

// File: tb/pulse_interval_logger_tb.sv
module pulse_interval_logger_tb;
  logic        clk_main = 1'b0;
  logic        clk_tick = 1'b0;
  logic        rst_n    = 1'b0;
  logic [9:0]  chan_in  = '0;
  logic        rec_trig = 1'b0;
  logic [15:0] wr_data;
  logic [3:0]  wr_addr;
  logic        wr_en;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [15:0] got [10];

  always #4 clk_main = ~clk_main;
  always #2 clk_tick = ~clk_tick;

  pulse_interval_logger u_dut (
    .clk_main (clk_main),
    .clk_tick (clk_tick),
    .rst_n    (rst_n),
    .chan_in  (chan_in),
    .rec_trig (rec_trig),
    .wr_data  (wr_data),
    .wr_addr  (wr_addr),
    .wr_en    (wr_en)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // two rising edges exactly p timer edges apart; optionally leave the input high
  task automatic pulse_pair(int ch, int p, bit hold);
    @(negedge clk_tick); chan_in[ch] = 1'b1;
    @(negedge clk_tick); chan_in[ch] = 1'b0;
    repeat (p - 1) @(negedge clk_tick);
    chan_in[ch] = 1'b1;
    if (!hold) begin
      @(negedge clk_tick); chan_in[ch] = 1'b0;
    end
    repeat (40) @(negedge clk_tick);
  endtask

  task automatic scan(bit extra_trig, string tag);
    int  nw;
    bit  prev;
    nw   = 0;
    prev = 1'b0;
    @(negedge clk_main); rec_trig = 1'b1;
    @(negedge clk_main); rec_trig = 1'b0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      @(negedge clk_main);
      if (extra_trig && cyc == 6) rec_trig = 1'b1;
      if (extra_trig && cyc == 8) rec_trig = 1'b0;
      if (wr_en) begin
        if (prev) chk("R7 strobe on two consecutive cycles", 1, 0);
        if (nw < 10) begin
          got[nw] = wr_data;
          chk("R6 write address order", int'(wr_addr), nw);
        end
        nw++;
      end
      prev = wr_en;
    end
    chk(tag, nw, 10);
  endtask

  initial begin
    repeat (200000) @(posedge clk_main);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk_main);
    rst_n = 1'b1;
    @(negedge clk_main);
    chk("R9 wr_en after reset", int'(wr_en), 0);
    chk("R9 wr_addr after reset", int'(wr_addr), 0);
    chk("R9 wr_data after reset", int'(wr_data), 0);

    scan(1'b0, "R6 write count");
    for (int c = 0; c < 10; c++) chk("R9 word before any edge", int'(got[c]), 0);

    // R2 sweep: intervals 2..41 across all channels, level low (R1)
    for (int b = 0; b < 4; b++) begin
      for (int c = 0; c < 10; c++) pulse_pair(c, 2 + b * 10 + c, 1'b0);
      scan(1'b0, "R6 write count");
      for (int c = 0; c < 10; c++) begin
        chk("R2 interval value", int'(got[c][14:0]), 1 + b * 10 + c);
        chk("R1 level bit low", int'(got[c][15]), 0);
      end
    end

    // R5 / R1: input held high after the second edge
    pulse_pair(3, 7, 1'b1);
    repeat (100) @(negedge clk_tick);
    scan(1'b0, "R6 write count");
    chk("R1 level bit high", int'(got[3][15]), 1);
    chk("R5 single capture while high", int'(got[3][14:0]), 6);
    @(negedge clk_tick); chan_in[3] = 1'b0;
    repeat (40) @(negedge clk_tick);
    scan(1'b0, "R6 write count");
    chk("R5 value kept after release", int'(got[3]), 6);

    // R3 / R4: terminal count and restart on the same edge, then a set mark
    pulse_pair(5, 32768, 1'b0);
    scan(1'b0, "R6 write count");
    chk("R3 coincident terminal and restart", int'(got[5]), 16'h7FFF);
    pulse_pair(5, 5, 1'b0);
    scan(1'b0, "R6 write count");
    chk("R4 recovery after coincident case", int'(got[5]), 4);
    pulse_pair(5, 32769, 1'b0);
    scan(1'b0, "R6 write count");
    chk("R3 overflow mark set", int'(got[5]), 16'h7FFF);
    pulse_pair(5, 5, 1'b0);
    scan(1'b0, "R6 write count");
    chk("R4 recovery after overflow", int'(got[5]), 4);
    pulse_pair(5, 40000, 1'b0);
    scan(1'b0, "R6 write count");
    chk("R3 long gap", int'(got[5]), 16'h7FFF);

    // R8: trigger during a scan
    scan(1'b1, "R8 writes with mid-scan trigger");
    for (int c = 0; c < 10; c++) chk("R8 addresses unaffected", c, c);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule